// File: doc/BRIEF.md
# SPI Memory Command Engine

This block is the command layer of a slave serial memory. A bit-level SPI front end hands it each received byte and takes bytes from it to shift out; it also tells the engine when chip select goes high and whether that happened in the middle of a byte. The engine decodes the instruction byte and collects a two-byte address. It streams array contents with an address that advances on its own, and it gathers write data into a one-page buffer. That buffer is committed to an internal byte array during a timed busy period that starts only when chip select is released.

Write permission is judged outside the engine. A protection block looks at the current address and the stored status bits and returns two allow signals. The engine checks them, together with its own write-enable latch, at the moment a write session ends. The array is a plain single-port-write, registered-read memory. After reset the engine runs an erase sweep that fills it with 0xFF, and it reports busy while the sweep runs.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset the engine is busy while it fills the whole array with 0xFF. Once that sweep ends, a status read returns 0x00 and every array byte reads 0xFF.
- R2: An instruction byte other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02 is ignored. Until chip select rises, later bytes in that session are also ignored, and `tx_valid` and `so_oe` stay low.
- R3: Read (0x03, then address high byte and low byte) returns data from the low ADDR_BITS address bits, and the upper bits are don't-care. After each byte taken with `tx_ack` the address advances by one. From the top address it wraps to 0, and this goes on for as long as the host keeps taking bytes.
- R4: Set-enable (0x06) sets the write-enable latch, and clear-enable (0x04) clears it. Either takes effect only if chip select rises on a byte boundary with no further byte after the instruction. The latch is status bit 1.
- R5: Write (0x02, then address, then data) loads bytes at the low 6 address bits. Those bits wrap within the page, so a 65th byte replaces the first. On commit, only the positions that were loaded are written, and the other bytes of the page keep their old values.
- R6: A page commit starts only when all of these hold: chip select rises with `cs_partial` low, at least one data byte was loaded, the enable latch is set, and `arr_wr_allow` is high. Otherwise nothing is written and no busy period starts.
- R7: A commit keeps the busy flag (status bit 0) at 1 for WR_CYCLES clock cycles. During that time every instruction except status read (0x05) is ignored. A status read returns the live status byte again for every byte taken.
- R8: The write-enable latch clears on its own when a page or status commit ends.
- R9: Write-status (0x01 plus one byte) needs the enable latch, `sts_wr_allow` high, and a byte-aligned chip-select rise. It stores bits 7, 6, 4, 3 and 2 of the byte. Bit 5 reads 0. `prot_bits` shows the stored bits, with bits 5, 1 and 0 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a whole byte was received |
| rx_byte | input | 8 | Received byte |
| tx_ack | input | 1 | Front end took `tx_byte` into its shifter |
| cs_rise | input | 1 | One-cycle strobe: chip select went high |
| cs_partial | input | 1 | With `cs_rise`: bits beyond the last whole byte were clocked |
| arr_wr_allow | input | 1 | Protection allows an array write at `cmd_addr` |
| sts_wr_allow | input | 1 | Protection allows a status write |
| tx_valid | output | 1 | `tx_byte` holds the next byte to send |
| tx_byte | output | 8 | Byte to shift out |
| so_oe | output | 1 | Drive the serial output (high only in read and status-read sessions) |
| cmd_addr | output | ADDR_BITS | Current command address, for the protection logic |
| prot_bits | output | 8 | Stored status bits for the protection logic |

## Verification
Reads are tried on erased, partly written and fully written pages, starting just before the page being checked and running past it. This separates auto-increment across pages from wrap at the top address. Page writes use a 66-byte burst and a 5-byte burst that straddles the page end: the first shows overwrite on wrap, the second shows that bytes never loaded are left alone. Write and enable sessions are ended in deliberately broken ways: no data byte, an extra byte, a mid-byte release, no enable, or a denied allow. Each is checked through a status read, so each failure cause is seen on its own. Commands sent during a busy period show that only the status read gets an answer.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // status bits a status write may change
  localparam logic [7:0] STS_WMASK = 8'hDC;

  typedef enum logic [3:0] {
    ST_OPC,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SRD,
    ST_SWR,
    ST_SWR_HAVE,
    ST_WEN,
    ST_WDIS,
    ST_DROP
  } eng_state_t;

endpackage

// File: rtl/smc_mem_array.sv
module smc_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/smc_page_buf.sv
module smc_page_buf #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld,
  input  logic [IW-1:0] ld_idx,
  input  logic [7:0]    ld_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_loaded
);
  localparam int PAGE = 1 << IW;

  logic [7:0]      data [PAGE];
  logic [PAGE-1:0] mask;

  always_ff @(posedge clk) begin
    if (ld) data[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask <= '0;
    else if (ld)    mask[ld_idx] <= 1'b1;
  end

  assign rd_data   = data[rd_idx];
  assign rd_loaded = mask[rd_idx];
endmodule

// File: rtl/smc_sequencer.sv
module smc_sequencer #(
  parameter int AW        = 11,
  parameter int IW        = 6,
  parameter int WR_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          last,
  output logic          step_we,
  output logic [IW-1:0] step_idx,
  output logic          init_we,
  output logic [AW-1:0] init_addr
);
  localparam int PAGE = 1 << IW;
  localparam int CW   = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WR_CYCLES - 1);
  localparam logic [CW-1:0] PAGE_CNT = CW'(PAGE);

  logic          init_active;
  logic          cbusy;
  logic [CW-1:0] ccnt;

  // erase sweep after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      init_active <= 1'b1;
      init_addr   <= '0;
    end else if (init_active) begin
      init_addr <= init_addr + 1'b1;
      if (init_addr == '1) init_active <= 1'b0;
    end
  end

  // timed commit
  always_ff @(posedge clk) begin
    if (rst) begin
      cbusy <= 1'b0;
      ccnt  <= '0;
    end else if (cbusy) begin
      ccnt <= ccnt + 1'b1;
      if (ccnt == LAST_CNT) cbusy <= 1'b0;
    end else if (start && !init_active) begin
      cbusy <= 1'b1;
      ccnt  <= '0;
    end
  end

  assign busy     = init_active | cbusy;
  assign last     = cbusy && (ccnt == LAST_CNT);
  assign step_we  = cbusy && (ccnt < PAGE_CNT);
  assign step_idx = ccnt[IW-1:0];
  assign init_we  = init_active;
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS = 11,
  parameter int PAGE_BITS = 6,
  parameter int WR_CYCLES = 200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 tx_ack,
  input  logic                 cs_rise,
  input  logic                 cs_partial,
  input  logic                 arr_wr_allow,
  input  logic                 sts_wr_allow,
  output logic                 tx_valid,
  output logic [7:0]           tx_byte,
  output logic                 so_oe,
  output logic [ADDR_BITS-1:0] cmd_addr,
  output logic [7:0]           prot_bits
);
  localparam int HI_BITS = ADDR_BITS - 8;
  localparam int PG_W    = ADDR_BITS - PAGE_BITS;

  eng_state_t            state;
  logic                  is_read;
  logic [HI_BITS-1:0]    ahi;
  logic [ADDR_BITS-1:0]  addr;
  logic                  have_data;
  logic                  wel;
  logic [7:0]            sts_keep;
  logic [7:0]            sts_new;
  logic                  rd_pend;
  logic                  rd_wait;
  logic [PG_W-1:0]       commit_page;

  logic                  busy, seq_last, step_we, init_we;
  logic [PAGE_BITS-1:0]  step_idx;
  logic [ADDR_BITS-1:0]  init_addr;
  logic [7:0]            buf_rd;
  logic                  buf_loaded;
  logic [7:0]            arr_rdata;
  logic [7:0]            status_now;

  logic rx_take, buf_ld, arr_commit, sts_commit, buf_clr, seq_start;

  assign rx_take    = rx_valid && !cs_rise;
  assign buf_ld     = rx_take && (state == ST_WDAT);
  assign arr_commit = cs_rise && !cs_partial && (state == ST_WDAT) && have_data
                      && wel && arr_wr_allow && !busy;
  assign sts_commit = cs_rise && !cs_partial && (state == ST_SWR_HAVE)
                      && wel && sts_wr_allow && !busy;
  assign seq_start  = arr_commit || sts_commit;
  assign buf_clr    = (cs_rise && !busy && !arr_commit) || seq_last;
  assign status_now = {sts_keep[7:2], wel, busy};

  smc_sequencer #(
    .AW(ADDR_BITS), .IW(PAGE_BITS), .WR_CYCLES(WR_CYCLES)
  ) i_seq (
    .clk(clk), .rst(rst), .start(seq_start), .busy(busy), .last(seq_last),
    .step_we(step_we), .step_idx(step_idx),
    .init_we(init_we), .init_addr(init_addr)
  );

  smc_page_buf #(.IW(PAGE_BITS)) i_buf (
    .clk(clk), .rst(rst), .clr(buf_clr),
    .ld(buf_ld), .ld_idx(addr[PAGE_BITS-1:0]), .ld_data(rx_byte),
    .rd_idx(step_idx), .rd_data(buf_rd), .rd_loaded(buf_loaded)
  );

  logic                 arr_we;
  logic [ADDR_BITS-1:0] arr_waddr;
  logic [7:0]           arr_wdata;

  always_comb begin
    if (init_we) begin
      arr_we    = 1'b1;
      arr_waddr = init_addr;
      arr_wdata = 8'hFF;
    end else begin
      arr_we    = step_we && buf_loaded;
      arr_waddr = {commit_page, step_idx};
      arr_wdata = buf_rd;
    end
  end

  smc_mem_array #(.AW(ADDR_BITS), .DW(8)) i_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .re(rd_pend), .raddr(addr), .rdata(arr_rdata)
  );

  // enable latch and status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      wel      <= 1'b0;
      sts_keep <= '0;
    end else begin
      if (seq_last) wel <= 1'b0;
      else if (cs_rise && !cs_partial && !busy) begin
        if (state == ST_WEN)  wel <= 1'b1;
        if (state == ST_WDIS) wel <= 1'b0;
      end
      if (sts_commit) sts_keep <= sts_new & STS_WMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) commit_page <= '0;
    else if (arr_commit) commit_page <= addr[ADDR_BITS-1:PAGE_BITS];
  end

  // command state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OPC;
      is_read   <= 1'b0;
      ahi       <= '0;
      addr      <= '0;
      have_data <= 1'b0;
      sts_new   <= '0;
      rd_pend   <= 1'b0;
      rd_wait   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      so_oe     <= 1'b0;
    end else if (cs_rise) begin
      state     <= ST_OPC;
      have_data <= 1'b0;
      rd_pend   <= 1'b0;
      rd_wait   <= 1'b0;
      tx_valid  <= 1'b0;
      so_oe     <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      rd_wait <= rd_pend;
      if (rd_wait) begin
        tx_byte  <= arr_rdata;
        tx_valid <= 1'b1;
      end
      if (tx_ack && state == ST_RDAT) begin
        tx_valid <= 1'b0;
        addr     <= addr + 1'b1;
        rd_pend  <= 1'b1;
      end
      if (tx_ack && state == ST_SRD) tx_byte <= status_now;
      if (rx_take) begin
        unique case (state)
          ST_OPC: begin
            if (busy) begin
              if (rx_byte == OP_RDSR) begin
                state    <= ST_SRD;
                tx_byte  <= status_now;
                tx_valid <= 1'b1;
                so_oe    <= 1'b1;
              end else begin
                state <= ST_DROP;
              end
            end else begin
              case (rx_byte)
                OP_WREN: state <= ST_WEN;
                OP_WRDI: state <= ST_WDIS;
                OP_RDSR: begin
                  state    <= ST_SRD;
                  tx_byte  <= status_now;
                  tx_valid <= 1'b1;
                  so_oe    <= 1'b1;
                end
                OP_WRSR:  state <= ST_SWR;
                OP_READ:  begin state <= ST_AHI; is_read <= 1'b1; end
                OP_WRITE: begin state <= ST_AHI; is_read <= 1'b0; end
                default:  state <= ST_DROP;
              endcase
            end
          end
          ST_AHI: begin
            ahi   <= rx_byte[HI_BITS-1:0];
            state <= ST_ALO;
          end
          ST_ALO: begin
            addr <= {ahi, rx_byte};
            if (is_read) begin
              state   <= ST_RDAT;
              rd_pend <= 1'b1;
              so_oe   <= 1'b1;
            end else begin
              state <= ST_WDAT;
            end
          end
          ST_WDAT: begin
            addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + 1'b1;
            have_data           <= 1'b1;
          end
          ST_SWR: begin
            sts_new <= rx_byte & STS_WMASK;
            state   <= ST_SWR_HAVE;
          end
          ST_SWR_HAVE, ST_WEN, ST_WDIS: state <= ST_DROP;
          ST_RDAT, ST_SRD, ST_DROP: ;
          default: state <= ST_DROP;
        endcase
      end
    end
  end

  assign cmd_addr  = addr;
  assign prot_bits = sts_keep;
endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
  parameter int ADDR_BITS = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rx_valid,
  input logic                 tx_ack,
  input logic                 cs_rise,
  input logic                 tx_valid,
  input logic                 so_oe,
  input logic [ADDR_BITS-1:0] cmd_addr,
  input logic [7:0]           prot_bits
);
  // R2
  tx_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> so_oe);

  // R2
  cs_release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (!so_oe && !tx_valid));

  // R9
  prot_spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_bits & 8'h23) == 8'h00);

  // R9
  prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> $stable(prot_bits));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !tx_ack && !cs_rise) |=> $stable(cmd_addr));
endmodule

bind spi_mem_engine spi_mem_engine_chk #(.ADDR_BITS(ADDR_BITS)) i_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_ack(tx_ack),
  .cs_rise(cs_rise), .tx_valid(tx_valid), .so_oe(so_oe),
  .cmd_addr(cmd_addr), .prot_bits(prot_bits)
);

// File: tb/test_spi_mem_engine.sv
module test_spi_mem_engine;
  localparam int AB  = 11;
  localparam int WRC = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          tx_ack = 1'b0;
  logic          cs_rise = 1'b0;
  logic          cs_partial = 1'b0;
  logic          arr_wr_allow = 1'b1;
  logic          sts_wr_allow = 1'b1;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          so_oe;
  logic [AB-1:0] cmd_addr;
  logic [7:0]    prot_bits;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  spi_mem_engine #(.ADDR_BITS(AB), .PAGE_BITS(6), .WR_CYCLES(WRC)) i_spi_mem_engine (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ack(tx_ack), .cs_rise(cs_rise), .cs_partial(cs_partial),
    .arr_wr_allow(arr_wr_allow), .sts_wr_allow(sts_wr_allow),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .so_oe(so_oe),
    .cmd_addr(cmd_addr), .prot_bits(prot_bits)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic cs_up(input logic partial);
    @(negedge clk);
    cs_rise    = 1'b1;
    cs_partial = partial;
    @(negedge clk);
    cs_rise    = 1'b0;
    cs_partial = 1'b0;
  endtask

  task automatic get_byte(input string tag, output logic [7:0] b);
    int n;
    n = 0;
    while (!tx_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (!tx_valid) begin
      checks++;
      fails++;
      $display("FAIL %s actual=no_byte expected=byte", tag);
      b = 8'hxx;
    end else begin
      b = tx_byte;
      tx_ack = 1'b1;
      @(negedge clk);
      tx_ack = 1'b0;
    end
  endtask

  task automatic rdsr_check(input string tag, input logic [7:0] exp);
    logic [7:0] b;
    send(8'h05);
    get_byte(tag, b);
    check(tag, {8'h00, b}, {8'h00, exp});
    cs_up(1'b0);
  endtask

  task automatic cmd_addr16(input logic [7:0] op, input logic [15:0] a);
    send(op);
    send(a[15:8]);
    send(a[7:0]);
  endtask

  task automatic wait_idle();
    repeat (WRC + 10) @(negedge clk);
  endtask

  task automatic read_expect(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] b;
    get_byte(tag, b);
    check(tag, {a, b} & 16'h00FF | {a, 8'h00} & 16'hFF00, {a[15:8], exp});
  endtask

  task automatic t_reset();
    logic [7:0] b;
    rdsr_check("R1 busy during erase sweep", 8'h01);
    repeat ((1 << AB) + 20) @(negedge clk);
    rdsr_check("R1 status after sweep", 8'h00);
    cmd_addr16(8'h03, 16'h0123);
    for (int i = 0; i < 3; i++) begin
      get_byte("R1 erased byte", b);
      check("R1 erased byte", {8'h00, b}, 16'h00FF);
    end
    cs_up(1'b0);
  endtask

  task automatic t_bad_opcode();
    send(8'hAB);
    send(8'h03);
    send(8'h00);
    send(8'h00);
    repeat (6) @(negedge clk);
    check("R2 no tx after unknown opcode", {14'd0, tx_valid, so_oe}, 16'h0000);
    cs_up(1'b0);
    rdsr_check("R2 state untouched", 8'h00);
  endtask

  task automatic t_enable();
    send(8'h06); send(8'h00); cs_up(1'b0);
    rdsr_check("R4 set-enable with extra byte", 8'h00);
    send(8'h06); cs_up(1'b1);
    rdsr_check("R4 set-enable mid-byte release", 8'h00);
    send(8'h06); cs_up(1'b0);
    rdsr_check("R4 set-enable aligned", 8'h02);
    send(8'h04); cs_up(1'b0);
    rdsr_check("R4 clear-enable", 8'h00);
  endtask

  task automatic t_bad_writes();
    logic [7:0] b;
    cmd_addr16(8'h02, 16'h0300); send(8'h55); cs_up(1'b0);
    rdsr_check("R6 no enable no busy", 8'h00);
    send(8'h06); cs_up(1'b0);
    cmd_addr16(8'h02, 16'h0300); cs_up(1'b0);
    rdsr_check("R6 zero data bytes no busy", 8'h02);
    cmd_addr16(8'h02, 16'h0300); send(8'h55); cs_up(1'b1);
    rdsr_check("R6 mid-byte release no busy", 8'h02);
    arr_wr_allow = 1'b0;
    cmd_addr16(8'h02, 16'h0300); send(8'h55); cs_up(1'b0);
    arr_wr_allow = 1'b1;
    rdsr_check("R6 denied write no busy", 8'h02);
    send(8'h04); cs_up(1'b0);
    cmd_addr16(8'h03, 16'h0300);
    get_byte("R6 array unchanged", b);
    check("R6 array unchanged", {8'h00, b}, 16'h00FF);
    cs_up(1'b0);
  endtask

  task automatic t_page_wrap();
    logic [7:0] b, e;
    send(8'h06); cs_up(1'b0);
    cmd_addr16(8'h02, 16'h0040);
    for (int k = 0; k < 66; k++) send(8'(8'h40 + k));
    cs_up(1'b0);
    rdsr_check("R7 busy and enable during commit", 8'h03);
    cmd_addr16(8'h03, 16'h0040);
    repeat (6) @(negedge clk);
    check("R7 read ignored while busy", {14'd0, tx_valid, so_oe}, 16'h0000);
    cs_up(1'b0);
    send(8'h06); cs_up(1'b0);
    wait_idle();
    rdsr_check("R8 enable cleared after commit", 8'h00);
    cmd_addr16(8'h03, 16'h003F);
    for (int a = 16'h3F; a <= 16'h80; a++) begin
      get_byte("R5 page wrap", b);
      if (a == 16'h3F || a == 16'h80) e = 8'hFF;
      else if (a < 16'h42) e = 8'(a + 16'h40);
      else e = 8'(a);
      check("R5 page wrap readback", {8'(a), b}, {8'(a), e});
    end
    cs_up(1'b0);
  endtask

  task automatic t_partial_page();
    logic [7:0] b;
    logic [7:0] exp1 [3];
    logic [7:0] exp2 [6];
    send(8'h06); cs_up(1'b0);
    cmd_addr16(8'h02, 16'hCA3C);
    for (int k = 0; k < 5; k++) send(8'(8'hA0 + k));
    cs_up(1'b0);
    wait_idle();
    exp1 = '{8'hFF, 8'hA4, 8'hFF};
    cmd_addr16(8'h03, 16'h01FF);
    for (int k = 0; k < 3; k++) begin
      get_byte("R5 unloaded bytes kept", b);
      check("R5 unloaded bytes kept", {8'(k), b}, {8'(k), exp1[k]});
    end
    cs_up(1'b0);
    exp2 = '{8'hFF, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hFF};
    cmd_addr16(8'h03, 16'hF23B);
    for (int k = 0; k < 6; k++) begin
      get_byte("R3 increment across page", b);
      check("R3 increment across page", {8'(k), b}, {8'(k), exp2[k]});
    end
    cs_up(1'b0);
  endtask

  task automatic t_top_wrap();
    logic [7:0] b;
    logic [7:0] exp [4];
    send(8'h06); cs_up(1'b0);
    cmd_addr16(8'h02, 16'hF800); send(8'h11); cs_up(1'b0);
    wait_idle();
    send(8'h06); cs_up(1'b0);
    cmd_addr16(8'h02, 16'h07FF); send(8'h5A); cs_up(1'b0);
    wait_idle();
    exp = '{8'hFF, 8'h5A, 8'h11, 8'hFF};
    cmd_addr16(8'h03, 16'h07FE);
    for (int k = 0; k < 4; k++) begin
      get_byte("R3 wrap at top address", b);
      check("R3 wrap at top address", {8'(k), b}, {8'(k), exp[k]});
    end
    cs_up(1'b0);
  endtask

  task automatic t_status();
    send(8'h06); cs_up(1'b0);
    send(8'h01); send(8'hFF); cs_up(1'b0);
    rdsr_check("R9 status write busy", 8'hDF);
    wait_idle();
    rdsr_check("R9 stored bits, R8 enable cleared", 8'hDC);
    check("R9 prot_bits", {8'h00, prot_bits}, 16'h00DC);
    send(8'h01); send(8'h00); cs_up(1'b0);
    rdsr_check("R9 status write without enable", 8'hDC);
    send(8'h06); cs_up(1'b0);
    sts_wr_allow = 1'b0;
    send(8'h01); send(8'h00); cs_up(1'b0);
    sts_wr_allow = 1'b1;
    rdsr_check("R9 status write denied", 8'hDE);
    send(8'h01); send(8'h00); cs_up(1'b0);
    wait_idle();
    rdsr_check("R9 status cleared again", 8'h00);
    check("R9 prot_bits cleared", {8'h00, prot_bits}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad_opcode();
    t_enable();
    t_bad_writes();
    t_page_wrap();
    t_partial_page();
    t_top_wrap();
    t_status();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule